// File: doc/BRIEF.md
# Multi-CPU Auto-Masking Interrupt Controller

This block collects a parameterised number of level-sensitive peripheral request lines and delivers them to several processors. Software can also raise each line through its own trigger bit. That bit is ORed with the wire. Each line has one mask bit, which is shared by all CPUs, and an affinity field that chooses which CPUs may take it. Every CPU also owns two inter-processor interrupts, and any agent can raise either one for any CPU.

Each CPU takes its interrupts through one event register. A read of that register returns the most urgent source for that CPU and acknowledges it in the same access. For a hardware line, the acknowledge sets the line's mask bit. For an IPI, it clears the pending bit and sets that CPU's mask bit for that IPI. Software must unmask a source before it can be delivered again. The event and IPI-status registers can be reached through a self view, which is steered by the `bus_cpu` input, or through an explicit view for each CPU.

All addresses are word indices. Mask set is at 0x00 and mask clear at 0x01, and both read back the mask. Trigger set is at 0x02 and trigger clear at 0x03, and both read back the trigger bits. The effective level reads at 0x04. IPI-0 send is at 0x05 and IPI-1 send at 0x06. Affinity of line i is at 0x20+i. The self view is at 0x40 (event) and 0x41 (IPI status/unmask). The view of CPU c is at 0x80+2c (event) and 0x81+2c (IPI status/unmask).

Top module: `mcpu_irq_ctrl`

## Requirements
- R1: After reset every line is masked, every trigger bit is 0, every affinity is 1 (CPU 0 only), no IPI is pending or masked, `cpu_irq` is 0 and `bus_rdata` is 0.
- R2: A write to 0x00 sets the mask bits where the data has a 1, and a write to 0x01 clears them. Zero bits change nothing. Reads of 0x00 and 0x01 return the mask. A masked line never raises `cpu_irq` and is never returned by an event read.
- R3: The effective level of line i is `hw_irq[i]` OR trigger bit i. Writes to 0x02 and 0x03 set and clear trigger bits where the data has a 1, and zero bits change nothing. A read of 0x04 returns the effective levels.
- R4: Bit c of the affinity word at 0x20+i (read/write) allows CPU c to receive line i. `cpu_irq[c]` is registered: it is 1 one clock edge after CPU c has an unmasked level line in its affinity or an unmasked pending IPI.
- R5: Read data appears on `bus_rdata` on the clock edge that samples `bus_re`. Address 0x40 selects the event register of the CPU named by `bus_cpu`, and 0x80+2c selects the event register of CPU c.
- R6: An event word carries the kind in bits [31:16] (0 none, 1 hardware line, 2 IPI) and the source number in bits [15:0]. When nothing is eligible, the read returns 0 and changes no state.
- R7: Priority is IPI 0 first, then IPI 1, then the eligible hardware line with the lowest number.
- R8: An event read that returns a hardware line sets that line's mask bit and leaves its trigger bit unchanged.
- R9: A write of 1 to bit c at 0x05 (IPI 0) or 0x06 (IPI 1) makes that IPI pending at CPU c. An event read of an IPI clears its pending bit and sets its mask bit. The status register at 0x41 (self) or 0x81+2c reads {pending[1:0], mask[1:0]} in bits [3:0]. A write there clears the IPI mask bits where the data has a 1.
- R10: A pending IPI that is masked is held until it is unmasked, and is then delivered. An acknowledge by one CPU masks the line for every CPU in its affinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_irq | input | N_IRQ | Level-sensitive peripheral requests |
| bus_cpu | input | CPU_W | CPU making the access, used by the self view |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; event reads have side effects |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | N_CPU | Registered request line per CPU |

## Verification
The assertions assume that `bus_we` and `bus_re` are never high in the same cycle. They also assume that `bus_cpu` names an existing CPU and that `hw_irq` is synchronous to `clk`. The bench makes one access per task call and drops the strobe before the next one. It changes `hw_irq` and `bus_cpu` only on falling edges and keeps `bus_cpu` below the CPU count. Under these conditions the assertions check that an acknowledged hardware source is masked, that event words have well-formed kinds, that an empty read returns exactly zero, and that mask writes leave the expected bits.

// File: rtl/mcic_pkg.sv
`timescale 1ns/1ps
package mcic_pkg;
  localparam int BUS_W = 32;

  localparam int A_MSET  = 'h00;
  localparam int A_MCLR  = 'h01;
  localparam int A_SSET  = 'h02;
  localparam int A_SCLR  = 'h03;
  localparam int A_LEVEL = 'h04;
  localparam int A_IPI0  = 'h05;
  localparam int A_IPI1  = 'h06;
  localparam int A_AFF   = 'h20;
  localparam int A_SELF  = 'h40;
  localparam int A_PER   = 'h80;

  localparam logic [15:0] EV_NONE = 16'd0;
  localparam logic [15:0] EV_HW   = 16'd1;
  localparam logic [15:0] EV_IPI  = 16'd2;
endpackage

// File: rtl/mcic_first_one.sv
`timescale 1ns/1ps
// Lowest-index set bit finder: lower index wins.
module mcic_first_one #(
  parameter int N = 32,
  parameter int W = 5
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/mcic_cpu_sel.sv
`timescale 1ns/1ps
// Per-CPU event selection: IPI0, then IPI1, then lowest hardware line.
module mcic_cpu_sel
  import mcic_pkg::*;
#(
  parameter int N_IRQ = 32,
  parameter int IRQ_W = 5
) (
  input  logic [N_IRQ-1:0] elig,
  input  logic [1:0]       ipi_live,
  output logic             hit,
  output logic [BUS_W-1:0] word
);
  logic             hw_found;
  logic [IRQ_W-1:0] hw_idx;

  mcic_first_one #(.N(N_IRQ), .W(IRQ_W)) u_pe (
    .vec   (elig),
    .found (hw_found),
    .idx   (hw_idx)
  );

  assign hit = (|ipi_live) | hw_found;

  always_comb begin
    if (ipi_live[0])      word = {EV_IPI, 16'd0};
    else if (ipi_live[1]) word = {EV_IPI, 16'd1};
    else if (hw_found)    word = {EV_HW, 16'(hw_idx)};
    else                  word = {EV_NONE, 16'd0};
  end
endmodule

// File: rtl/mcpu_irq_ctrl.sv
`timescale 1ns/1ps
module mcpu_irq_ctrl
  import mcic_pkg::*;
#(
  parameter int N_IRQ  = 32,
  parameter int N_CPU  = 4,
  parameter int ADDR_W = 8,
  parameter int CPU_W  = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IRQ-1:0]  hw_irq,
  input  logic [CPU_W-1:0]  bus_cpu,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [N_CPU-1:0]  cpu_irq
);
  localparam int IRQ_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
  localparam logic [ADDR_W-1:0] AD_MSET  = ADDR_W'(A_MSET);
  localparam logic [ADDR_W-1:0] AD_MCLR  = ADDR_W'(A_MCLR);
  localparam logic [ADDR_W-1:0] AD_SSET  = ADDR_W'(A_SSET);
  localparam logic [ADDR_W-1:0] AD_SCLR  = ADDR_W'(A_SCLR);
  localparam logic [ADDR_W-1:0] AD_LEVEL = ADDR_W'(A_LEVEL);
  localparam logic [ADDR_W-1:0] AD_IPI0  = ADDR_W'(A_IPI0);
  localparam logic [ADDR_W-1:0] AD_IPI1  = ADDR_W'(A_IPI1);
  localparam logic [ADDR_W-1:0] AD_AFF   = ADDR_W'(A_AFF);
  localparam logic [ADDR_W-1:0] AD_AFFE  = ADDR_W'(A_AFF + N_IRQ);
  localparam logic [ADDR_W-1:0] AD_SELF  = ADDR_W'(A_SELF);
  localparam logic [ADDR_W-1:0] AD_SELF1 = ADDR_W'(A_SELF + 1);
  localparam logic [ADDR_W-1:0] AD_PER   = ADDR_W'(A_PER);
  localparam logic [ADDR_W-1:0] AD_PERE  = ADDR_W'(A_PER + 2 * N_CPU);

  // ---------------- state ----------------
  logic [N_IRQ-1:0] mask_q;
  logic [N_IRQ-1:0] swt_q;
  logic [N_CPU-1:0] aff_q      [N_IRQ];
  logic [1:0]       ipi_pend_q [N_CPU];
  logic [1:0]       ipi_mask_q [N_CPU];

  logic [N_IRQ-1:0] lvl;
  assign lvl = hw_irq | swt_q;

  // ---------------- per-CPU selection ----------------
  logic [N_CPU-1:0] hit;
  logic [BUS_W-1:0] word [N_CPU];

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic [N_IRQ-1:0] elig;
    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
      assign elig[i] = lvl[i] & ~mask_q[i] & aff_q[i][c];
    end
    mcic_cpu_sel #(.N_IRQ(N_IRQ), .IRQ_W(IRQ_W)) u_sel (
      .elig     (elig),
      .ipi_live (ipi_pend_q[c] & ~ipi_mask_q[c]),
      .hit      (hit[c]),
      .word     (word[c])
    );
  end

  // ---------------- address decode ----------------
  logic              self_hit, per_hit, view_ok, view_reg, aff_hit;
  logic [ADDR_W-1:0] per_off, aff_off;
  logic [CPU_W-1:0]  tgt;
  logic [IRQ_W-1:0]  aff_idx;

  always_comb begin
    self_hit = (bus_addr == AD_SELF) || (bus_addr == AD_SELF1);
    per_hit  = (bus_addr >= AD_PER) && (bus_addr < AD_PERE);
    per_off  = bus_addr - AD_PER;
    view_ok  = self_hit | per_hit;
    view_reg = self_hit ? (bus_addr == AD_SELF1) : per_off[0];
    tgt      = self_hit ? bus_cpu : CPU_W'(per_off >> 1);
    aff_hit  = (bus_addr >= AD_AFF) && (bus_addr < AD_AFFE);
    aff_off  = bus_addr - AD_AFF;
    aff_idx  = IRQ_W'(aff_off);
  end

  logic             ev_rd;
  logic [BUS_W-1:0] ev_word;
  logic [IRQ_W-1:0] ev_line;
  logic             ev_is_ipi;
  logic             ev_ipi_no;

  assign ev_rd     = bus_re && view_ok && !view_reg && hit[tgt];
  assign ev_word   = word[tgt];
  assign ev_line   = IRQ_W'(ev_word);
  assign ev_is_ipi = (ev_word[31:16] == EV_IPI);
  assign ev_ipi_no = ev_word[0];

  // ---------------- state update ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      swt_q  <= '0;
      for (int i = 0; i < N_IRQ; i++) aff_q[i] <= N_CPU'(1);
      for (int c = 0; c < N_CPU; c++) begin
        ipi_pend_q[c] <= '0;
        ipi_mask_q[c] <= '0;
      end
    end else begin
      if (bus_we) begin
        if (bus_addr == AD_MSET) mask_q <= mask_q | bus_wdata[N_IRQ-1:0];
        if (bus_addr == AD_MCLR) mask_q <= mask_q & ~bus_wdata[N_IRQ-1:0];
        if (bus_addr == AD_SSET) swt_q  <= swt_q | bus_wdata[N_IRQ-1:0];
        if (bus_addr == AD_SCLR) swt_q  <= swt_q & ~bus_wdata[N_IRQ-1:0];
        if (aff_hit) aff_q[aff_idx] <= bus_wdata[N_CPU-1:0];
        for (int c = 0; c < N_CPU; c++) begin
          if (bus_addr == AD_IPI0 && bus_wdata[c]) ipi_pend_q[c][0] <= 1'b1;
          if (bus_addr == AD_IPI1 && bus_wdata[c]) ipi_pend_q[c][1] <= 1'b1;
        end
        if (view_ok && view_reg)
          ipi_mask_q[tgt] <= ipi_mask_q[tgt] & ~bus_wdata[1:0];
      end
      if (ev_rd) begin
        if (ev_is_ipi) begin
          ipi_pend_q[tgt][ev_ipi_no] <= 1'b0;
          ipi_mask_q[tgt][ev_ipi_no] <= 1'b1;
        end else begin
          mask_q[ev_line] <= 1'b1;
        end
      end
    end
  end

  // ---------------- read path ----------------
  logic [BUS_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_addr == AD_MSET || bus_addr == AD_MCLR) rd_mux = BUS_W'(mask_q);
    else if (bus_addr == AD_SSET || bus_addr == AD_SCLR) rd_mux = BUS_W'(swt_q);
    else if (bus_addr == AD_LEVEL) rd_mux = BUS_W'(lvl);
    else if (bus_addr == AD_IPI0) begin
      for (int c = 0; c < N_CPU; c++) rd_mux[c] = ipi_pend_q[c][0];
    end else if (bus_addr == AD_IPI1) begin
      for (int c = 0; c < N_CPU; c++) rd_mux[c] = ipi_pend_q[c][1];
    end else if (aff_hit) rd_mux = BUS_W'(aff_q[aff_idx]);
    else if (view_ok) begin
      if (view_reg) rd_mux = BUS_W'({ipi_pend_q[tgt], ipi_mask_q[tgt]});
      else          rd_mux = ev_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      cpu_irq   <= '0;
    end else begin
      if (bus_re) bus_rdata <= rd_mux;
      cpu_irq <= hit;
    end
  end
endmodule

// File: rtl/mcpu_irq_ctrl_chk.sv
`timescale 1ns/1ps
module mcpu_irq_ctrl_chk
  import mcic_pkg::*;
#(
  parameter int N_IRQ  = 32,
  parameter int N_CPU  = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [N_IRQ-1:0]  mask_q
);
  localparam int IRQ_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  logic is_ev_addr, ev_rd_q;
  assign is_ev_addr = (bus_addr == ADDR_W'(A_SELF)) ||
                      ((bus_addr >= ADDR_W'(A_PER)) &&
                       (bus_addr < ADDR_W'(A_PER + 2 * N_CPU)) && !bus_addr[0]);

  always_ff @(posedge clk) begin
    if (rst) ev_rd_q <= 1'b0;
    else     ev_rd_q <= bus_re && is_ev_addr;
  end

  // R8: a returned hardware line is masked afterwards
  a_r8_ack_masks: assert property (@(posedge clk) disable iff (rst)
    (ev_rd_q && bus_rdata[31:16] == EV_HW) |-> mask_q[IRQ_W'(bus_rdata)]);

  // R6: event kind field is 0, 1 or 2
  a_r6_kind_range: assert property (@(posedge clk) disable iff (rst)
    ev_rd_q |-> (bus_rdata[31:16] <= EV_IPI));

  // R6: empty event read is all zero
  a_r6_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (ev_rd_q && bus_rdata[31:16] == EV_NONE) |-> (bus_rdata == '0));

  // R9: IPI events carry number 0 or 1
  a_r9_ipi_num: assert property (@(posedge clk) disable iff (rst)
    (ev_rd_q && bus_rdata[31:16] == EV_IPI) |-> (bus_rdata[15:0] < 16'd2));

  // R2: mask-set write leaves written bits set
  a_r2_mask_set: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(A_MSET)) |=>
      ((mask_q & $past(bus_wdata[N_IRQ-1:0])) == $past(bus_wdata[N_IRQ-1:0])));

  // R2: mask-clear write leaves written bits clear
  a_r2_mask_clr: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(A_MCLR)) |=>
      ((mask_q & $past(bus_wdata[N_IRQ-1:0])) == '0));
endmodule

bind mcpu_irq_ctrl mcpu_irq_ctrl_chk #(.N_IRQ(N_IRQ), .N_CPU(N_CPU), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_mcpu_irq_ctrl.sv
`timescale 1ns/1ps
module tb_mcpu_irq_ctrl;
  localparam int N_IRQ = 32, N_CPU = 4, ADDR_W = 8, CPU_W = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N_IRQ-1:0]  hw_irq = '0;
  logic [CPU_W-1:0]  bus_cpu = '0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0]       bus_rdata;
  logic [N_CPU-1:0]  cpu_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mcpu_irq_ctrl #(.N_IRQ(N_IRQ), .N_CPU(N_CPU), .ADDR_W(ADDR_W)) dut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic br(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 cpu_irq", 32'(cpu_irq), 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    br(8'h00, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    br(8'h02, d); chk("R1 trigger", d, 32'h0);
    br(8'h23, d); chk("R1 affinity", d, 32'h1);
    br(8'h41, d); chk("R1 ipi status", d, 32'h0);
    br(8'h40, d); chk("R1 R6 empty event", d, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    bw(8'h01, 32'h5); br(8'h00, d); chk("R2 clear", d, 32'hFFFF_FFFA);
    br(8'h01, d); chk("R2 read at clr", d, 32'hFFFF_FFFA);
    bw(8'h00, 32'h1); br(8'h00, d); chk("R2 set", d, 32'hFFFF_FFFB);
    bw(8'h01, 32'h0); br(8'h00, d); chk("R2 zero write", d, 32'hFFFF_FFFB);
    bw(8'h00, 32'h0); br(8'h00, d); chk("R2 zero set", d, 32'hFFFF_FFFB);
    hw_irq = 32'h1; settle();
    chk("R2 masked line silent", 32'(cpu_irq), 32'h0);
    hw_irq = '0;
  endtask

  task automatic t_level();
    logic [31:0] d;
    bus_cpu = 2'd0;
    hw_irq = 32'h4; settle();
    chk("R4 cpu_irq", 32'(cpu_irq), 32'h1);
    br(8'h04, d); chk("R3 level", d, 32'h4);
    br(8'h40, d); chk("R6 R5 event hw 2", d, 32'h0001_0002);
    br(8'h00, d); chk("R8 masked after ack", d, 32'hFFFF_FFFF);
    settle(); chk("R8 cpu_irq drops", 32'(cpu_irq), 32'h0);
    br(8'h40, d); chk("R6 empty read", d, 32'h0);
    br(8'h00, d); chk("R6 no state change", d, 32'hFFFF_FFFF);
    hw_irq = '0;
  endtask

  task automatic t_prio();
    logic [31:0] d;
    bw(8'h23, 32'h2); bw(8'h29, 32'h3);
    br(8'h23, d); chk("R4 affinity readback", d, 32'h2);
    hw_irq = 32'h0000_0208;
    bw(8'h01, 32'h0000_0208); settle();
    chk("R4 cpu_irq affinity", 32'(cpu_irq), 32'h3);
    br(8'h82, d); chk("R7 lowest first", d, 32'h0001_0003);
    br(8'h82, d); chk("R7 next line", d, 32'h0001_0009);
    br(8'h80, d); chk("R10 shared mask", d, 32'h0);
    settle(); chk("R10 cpu_irq clear", 32'(cpu_irq), 32'h0);
    hw_irq = '0;
  endtask

  task automatic t_soft();
    logic [31:0] d;
    bw(8'h02, 32'h80); bw(8'h01, 32'h80); settle();
    chk("R3 soft raises", 32'(cpu_irq), 32'h1);
    br(8'h04, d); chk("R3 level from soft", d, 32'h80);
    br(8'h40, d); chk("R3 soft event", d, 32'h0001_0007);
    br(8'h02, d); chk("R8 trigger kept", d, 32'h80);
    bw(8'h02, 32'h0); br(8'h02, d); chk("R3 zero set", d, 32'h80);
    bw(8'h03, 32'h80); br(8'h02, d); chk("R3 clear", d, 32'h0);
  endtask

  task automatic t_ipi();
    logic [31:0] d;
    bus_cpu = 2'd2;
    bw(8'h20, 32'h4); bw(8'h02, 32'h1); bw(8'h01, 32'h1);
    bw(8'h06, 32'h4); bw(8'h05, 32'h4);
    br(8'h05, d); chk("R9 ipi0 pending", d, 32'h4);
    settle(); chk("R9 cpu_irq ipi", 32'(cpu_irq), 32'h4);
    br(8'h40, d); chk("R7 ipi0 first", d, 32'h0002_0000);
    br(8'h40, d); chk("R7 ipi1 second", d, 32'h0002_0001);
    br(8'h40, d); chk("R7 hw after ipi", d, 32'h0001_0000);
    br(8'h85, d); chk("R9 status after ack", d, 32'h3);
    settle(); chk("R9 cpu_irq idle", 32'(cpu_irq), 32'h0);
    bw(8'h05, 32'h4); settle();
    chk("R10 masked ipi held", 32'(cpu_irq), 32'h0);
    br(8'h85, d); chk("R10 status pending", d, 32'h7);
    bw(8'h85, 32'h1); settle();
    chk("R10 unmask delivers", 32'(cpu_irq), 32'h4);
    br(8'h84, d); chk("R5 per-cpu view", d, 32'h0002_0000);
    bw(8'h03, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mask();
    t_level();
    t_prio();
    t_soft();
    t_ipi();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule